// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block takes a group of free-running synthesized clocks and sequences them into and out of a low-power state. The power-down request arrives asynchronously and is active low. The block synchronizes it to its control clock and rejects pulses that last a single cycle. It then stops each output low without shortening any pulse. Only when every output is confirmed parked does it drop the enables of the crystal oscillator and the VCO. On exit it restarts the oscillator and the VCO and waits a fixed number of control-clock cycles for them to settle. It then reopens each output during that output's low phase, so the first pulse that comes out has full width.

The oscillator, PLL and pad drivers are outside the block. They appear as enable outputs and as source clock inputs. In the model each source changes state just after a rising edge of the control clock. Each output has an enable register clocked on the falling edge of the control clock, and that register may change only while its source is low. A slow output, such as the reference clock, can therefore take several cycles to park, and the sequencer waits for it. Two separate stop requests, one for the CPU-rate outputs and one for the PCI outputs, gate their groups during normal running. The free-running PCI output belongs to neither group. The power-down sequence overrides both stop requests.

Top module: `clkpd_sequencer`

## Requirements
- R1: `pd_req_n`, `cpu_stop_n` and `pci_stop_n` each pass through two synchronizing flops, which reset to 1. The power-down request acts only after two consecutive synchronized samples agree. A low held across at least two rising edges, first sampled at rising edge k, moves the block out of normal running at edge k+3. A low seen at only one rising edge has no effect.
- R2: Each output equals its source ANDed with an enable register. That enable register is updated only at a falling edge of `clk` and only while the source is low. An output therefore never falls unless its source falls, and never rises unless its source rises.
- R3: Once gating begins, every enable is cleared at its first falling edge with a low source. `osc_en` and `vco_en` fall one rising edge after the sequencer observes all enables clear. They are never low while any enable is set.
- R4: `pd_done` is 1 exactly while the block rests in the powered-down state. In that state `osc_en` and `vco_en` are 0 and every output is 0.
- R5: A rise of `pd_req_n` after gating has started does not abort the sequence. The block still reaches the powered-down state and only then considers waking.
- R6: The stop inputs are active low. During normal running and release, `cpu_stop_n` low holds off the outputs in `CPU_MASK`, which defaults to bits 0 and 1. `pci_stop_n` low holds off the outputs in `PCI_MASK`, which defaults to bit 3. Bit 2, the free-running PCI output, is in neither mask. In every other state the stop inputs have no effect, and all outputs stay low.
- R7: When two agreeing synchronized high samples are seen in the powered-down state, `osc_en` and `vco_en` return to 1 at that edge. The block then stays in stabilization for `STAB_CYCLES` rising edges before it starts release.
- R8: During release each output's enable is set at a falling edge where its source is low, so the first output pulse has full width. Normal running resumes at the rising edge after all enables match the requested set.
- R9: If the request is accepted low again during stabilization, the block returns directly to the powered-down state. `osc_en` and `vco_en` fall at that edge and no output pulse appears.
- R10: After synchronous reset the block is in normal running with `osc_en` and `vco_en` at 1 and all enables clear. Each output then opens at its first low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock at CPU rate; sources change after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous stop for the CPU-rate output group, active low |
| pci_stop_n | input | 1 | Asynchronous stop for the PCI output group, active low |
| src_clk | input | NUM_OUT | Free-running source clocks from the synthesizer |
| clk_out | output | NUM_OUT | Gated output clocks |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| pd_done | output | 1 | High while fully powered down |

## Verification
The bench drives the slow reference source with seven-cycle half periods, so the parking wait is exercised. A design that killed the oscillator early would show `osc_en` low while that output was still high. A design that gated on the wrong phase would truncate a pulse or emit a runt, which the cycle-by-cycle model flags at once. The bench also sends a one-cycle glitch on the request, which a design without the agreement filter would turn into a full shutdown. It releases the request in the middle of gating and expects the sequence to finish anyway. It re-asserts the request during stabilization and expects no output pulse to escape. It toggles both stop inputs while powered down, where a design that honoured them would raise enables it must keep cleared.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

    typedef enum logic [2:0] {
        PS_RUN      = 3'd0,
        PS_GATING   = 3'd1,
        PS_WAIT_LOW = 3'd2,
        PS_OSC_OFF  = 3'd3,
        PS_WAKE     = 3'd4,
        PS_RELEASE  = 3'd5
    } pd_state_e;

    typedef struct packed {
        logic osc_en;
        logic vco_en;
        logic done;
        logic pass_stop;
    } pwr_ctl_t;

    // Moore decode of the sequencer state into its control outputs.
    function automatic pwr_ctl_t decode_ctl(pd_state_e s);
        pwr_ctl_t c;
        c.osc_en    = (s != PS_OSC_OFF);
        c.vco_en    = (s != PS_OSC_OFF);
        c.done      = (s == PS_OSC_OFF);
        c.pass_stop = (s == PS_RUN) || (s == PS_RELEASE);
        return c;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
    parameter int unsigned         WIDTH   = 3,
    parameter logic [WIDTH-1:0]    RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/clkpd_fsm.sv
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int unsigned          NUM_OUT     = 6,
    parameter logic [NUM_OUT-1:0]   CPU_MASK    = 6'b000011,
    parameter logic [NUM_OUT-1:0]   PCI_MASK    = 6'b001000,
    parameter int unsigned          STAB_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd_n_s,
    input  logic               cpu_stop_n_s,
    input  logic               pci_stop_n_s,
    input  logic [NUM_OUT-1:0] gate_en,
    output logic [NUM_OUT-1:0] want,
    output pd_state_e          state,
    output logic               osc_en,
    output logic               vco_en,
    output logic               pd_done
);
    localparam int unsigned    CW        = cnt_width(STAB_CYCLES);
    localparam logic [CW-1:0]  STAB_LOAD = CW'(STAB_CYCLES - 1);

    pd_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           pd_n_prev_q;
    logic           req_low, req_high;
    logic [NUM_OUT-1:0] run_want;
    pwr_ctl_t       ctl;

    // Agreement filter: one more sample of the synchronized request.
    always_ff @(posedge clk) begin
        if (rst) pd_n_prev_q <= 1'b1;
        else     pd_n_prev_q <= pd_n_s;
    end

    assign req_low  = !pd_n_s && !pd_n_prev_q;
    assign req_high =  pd_n_s &&  pd_n_prev_q;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_want
        assign run_want[g] = !((!cpu_stop_n_s && CPU_MASK[g]) ||
                               (!pci_stop_n_s && PCI_MASK[g]));
    end

    assign ctl  = decode_ctl(state_q);
    assign want = ctl.pass_stop ? run_want : '0;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_RUN:      if (req_low) state_d = PS_GATING;
            PS_GATING:   state_d = PS_WAIT_LOW;
            PS_WAIT_LOW: if (gate_en == '0) state_d = PS_OSC_OFF;
            PS_OSC_OFF: begin
                if (req_high) begin
                    state_d = PS_WAKE;
                    cnt_d   = STAB_LOAD;
                end
            end
            PS_WAKE: begin
                if (req_low)          state_d = PS_OSC_OFF;
                else if (cnt_q == '0) state_d = PS_RELEASE;
                else                  cnt_d   = cnt_q - 1'b1;
            end
            PS_RELEASE: begin
                if (req_low)              state_d = PS_GATING;
                else if (gate_en == want) state_d = PS_RUN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state   = state_q;
    assign osc_en  = ctl.osc_en;
    assign vco_en  = ctl.vco_en;
    assign pd_done = ctl.done;

    // R5: gating always advances to the wait-for-low state
    a_r5_gating_advances: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_GATING) |=> (state_q == PS_WAIT_LOW));

    // R5: a request release cannot leave the wait state while outputs are open
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAIT_LOW && gate_en != '0) |=> (state_q == PS_WAIT_LOW));

    // R7: expired stabilization count starts release
    a_r7_wake_expires: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAKE && cnt_q == '0 && !req_low) |=> (state_q == PS_RELEASE));

    // R9: re-asserted request during stabilization returns to power-down
    a_r9_wake_abort: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAKE && req_low) |=> (state_q == PS_OSC_OFF && !osc_en));

    // R1: a high synchronized sample keeps normal running from gating
    a_r1_filter_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN && pd_n_s) |=> (state_q == PS_RUN));
endmodule

// File: rtl/clkpd_gate.sv
module clkpd_gate #(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] src_clk,
    input  logic [NUM_OUT-1:0] want,
    output logic [NUM_OUT-1:0] gate_en,
    output logic [NUM_OUT-1:0] clk_out
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        logic en_q;

        // Falling-edge enable, updated only while the source is low.
        always_ff @(negedge clk) begin
            if (rst)               en_q <= 1'b0;
            else if (!src_clk[g])  en_q <= want[g];
        end

        assign gate_en[g] = en_q;
        assign clk_out[g] = src_clk[g] & en_q;

        // R2: an output may only fall together with its source
        a_r2_no_runt_fall: assert property (@(posedge clk) disable iff (rst)
            $fell(clk_out[g]) |-> $fell(src_clk[g]));

        // R2: an output may only rise together with its source (full first pulse)
        a_r2_no_runt_rise: assert property (@(posedge clk) disable iff (rst)
            $rose(clk_out[g]) |-> $rose(src_clk[g]));
    end
endmodule

// File: rtl/clkpd_sequencer.sv
module clkpd_sequencer
    import clkpd_pkg::*;
#(
    parameter int unsigned          NUM_OUT     = 6,
    parameter logic [NUM_OUT-1:0]   CPU_MASK    = 6'b000011,
    parameter logic [NUM_OUT-1:0]   PCI_MASK    = 6'b001000,
    parameter int unsigned          STAB_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd_req_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic [NUM_OUT-1:0] src_clk,
    output logic [NUM_OUT-1:0] clk_out,
    output logic               osc_en,
    output logic               vco_en,
    output logic               pd_done
);
    logic [2:0]         req_sync;
    logic [NUM_OUT-1:0] want;
    logic [NUM_OUT-1:0] gate_en;
    pd_state_e          state;

    clkpd_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({pd_req_n, cpu_stop_n, pci_stop_n}),
        .q_sync  (req_sync)
    );

    clkpd_fsm #(
        .NUM_OUT     (NUM_OUT),
        .CPU_MASK    (CPU_MASK),
        .PCI_MASK    (PCI_MASK),
        .STAB_CYCLES (STAB_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pd_n_s       (req_sync[2]),
        .cpu_stop_n_s (req_sync[1]),
        .pci_stop_n_s (req_sync[0]),
        .gate_en      (gate_en),
        .want         (want),
        .state        (state),
        .osc_en       (osc_en),
        .vco_en       (vco_en),
        .pd_done      (pd_done)
    );

    clkpd_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .src_clk (src_clk),
        .want    (want),
        .gate_en (gate_en),
        .clk_out (clk_out)
    );

    // R3: oscillator and VCO are off only while every enable is clear
    a_r3_osc_needs_gating: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (gate_en == '0));

    // R3: the oscillator enable drops only after all enables were already clear
    a_r3_osc_fall_order: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> ($past(gate_en) == '0));

    // R4: powered-down status implies quiet outputs and a stopped VCO
    a_r4_done_quiet: assert property (@(posedge clk) disable iff (rst)
        pd_done |-> (clk_out == '0 && !vco_en && state == PS_OSC_OFF));
endmodule

// File: tb/tb_clkpd_sequencer.sv
`timescale 1ns/1ps
module tb_clkpd_sequencer;
    localparam int          N     = 6;
    localparam int          STAB  = 24;
    localparam logic [N-1:0] CMASK = 6'b000011;
    localparam logic [N-1:0] PMASK = 6'b001000;

    localparam int M_RUN = 0, M_GATE = 1, M_WAIT = 2, M_OFF = 3, M_WAKE = 4, M_REL = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pd_req_n = 1'b1;
    logic         cpu_stop_n = 1'b1;
    logic         pci_stop_n = 1'b1;
    logic [N-1:0] src_clk = '0;
    logic [N-1:0] clk_out;
    logic         osc_en, vco_en, pd_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    clkpd_sequencer #(.NUM_OUT(N), .CPU_MASK(CMASK), .PCI_MASK(PMASK),
                      .STAB_CYCLES(STAB)) dut (
        .clk(clk), .rst(rst), .pd_req_n(pd_req_n), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .src_clk(src_clk), .clk_out(clk_out),
        .osc_en(osc_en), .vco_en(vco_en), .pd_done(pd_done));

    always #10 clk = ~clk;

    // Source clocks: half periods in control-clock cycles; bit 4 is the slow reference.
    initial begin
        int half [N];
        int cnt  [N];
        half = '{1, 2, 4, 4, 7, 3};
        for (int i = 0; i < N; i++) cnt[i] = 0;
        forever begin
            @(posedge clk);
            #1;
            for (int i = 0; i < N; i++) begin
                if (cnt[i] == half[i] - 1) begin
                    src_clk[i] = ~src_clk[i];
                    cnt[i] = 0;
                end else begin
                    cnt[i]++;
                end
            end
        end
    end

    // Behavioural reference model.
    int           m_state = M_RUN;
    int           m_cnt   = 0;
    logic [N-1:0] m_en    = '0;
    logic [N-1:0] m_want  = '0;
    bit           pd_hist  [$];
    bit           cpu_hist [$];
    bit           pci_hist [$];

    always @(posedge clk) begin
        if (rst) begin
            m_state  = M_RUN;
            m_cnt    = 0;
            pd_hist  = '{1'b1, 1'b1, 1'b1, 1'b1};
            cpu_hist = '{1'b1, 1'b1};
            pci_hist = '{1'b1, 1'b1};
        end else begin
            bit lo, hi;
            pd_hist.push_front(pd_req_n);   void'(pd_hist.pop_back());
            cpu_hist.push_front(cpu_stop_n); void'(cpu_hist.pop_back());
            pci_hist.push_front(pci_stop_n); void'(pci_hist.pop_back());
            lo = !pd_hist[2] && !pd_hist[3];
            hi =  pd_hist[2] &&  pd_hist[3];
            case (m_state)
                M_RUN:  if (lo) m_state = M_GATE;
                M_GATE: m_state = M_WAIT;
                M_WAIT: if (m_en == '0) m_state = M_OFF;
                M_OFF:  if (hi) begin m_state = M_WAKE; m_cnt = STAB - 1; end
                M_WAKE: begin
                    if (lo) m_state = M_OFF;
                    else if (m_cnt == 0) m_state = M_REL;
                    else m_cnt--;
                end
                default: begin
                    if (lo) m_state = M_GATE;
                    else if (m_en == m_want) m_state = M_RUN;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            bit held;
            held = (!cpu_hist[1] && CMASK[i]) || (!pci_hist[1] && PMASK[i]);
            m_want[i] = (m_state == M_RUN || m_state == M_REL) ? !held : 1'b0;
        end
        if (rst) m_en = '0;
        else for (int i = 0; i < N; i++) if (!src_clk[i]) m_en[i] = m_want[i];
    end

    task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, sampled just before the falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #9;
            if (!rst && !finished) begin
                check("R2", "clk_out", clk_out, src_clk & m_en);
                check("R3", "osc_en", N'(osc_en), N'(m_state != M_OFF));
                check("R3", "vco_en", N'(vco_en), N'(m_state != M_OFF));
                check("R4", "pd_done", N'(pd_done), N'(m_state == M_OFF));
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_done(string req, int limit);
        int k = 0;
        while (!pd_done && k < limit) begin tick(); k++; end
        check(req, "reached power-down", N'(pd_done), N'(1));
    endtask

    task automatic summary();
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20ns * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [N-1:0] seen;
        int           k;
        tick(4);
        rst = 1'b0;
        // R10: reset state
        check("R10", "osc_en after reset", N'(osc_en), N'(1));
        check("R10", "pd_done after reset", N'(pd_done), N'(0));
        seen = '0;
        repeat (20) begin tick(); seen |= clk_out; end
        check("R10", "all outputs opened", seen, '1);

        // R1: one-cycle glitch is rejected
        pd_req_n = 1'b0; tick(); pd_req_n = 1'b1;
        k = 0;
        repeat (15) begin tick(); if (!osc_en || pd_done) k++; end
        check("R1", "glitch ignored", N'(k), N'(0));

        // R6: CPU stop holds bits 0,1; free PCI bit 2 keeps running
        cpu_stop_n = 1'b0; tick(10);
        seen = '0;
        repeat (20) begin tick(); seen |= clk_out; end
        check("R6", "cpu stop gating", seen & 6'b000111, 6'b000100);
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b0; tick(12);
        seen = '0;
        repeat (20) begin tick(); seen |= clk_out; end
        check("R6", "pci stop gating", seen & 6'b001100, 6'b000100);
        pci_stop_n = 1'b1; tick(12);

        // R3: full power-down, slow reference output must park first
        pd_req_n = 1'b0;
        wait_done("R3", 80);
        // R6: stops ignored while powered down
        seen = '0;
        repeat (6) begin cpu_stop_n = ~cpu_stop_n; pci_stop_n = ~pci_stop_n; tick(2); seen |= clk_out; end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        check("R6", "stops ignored in power-down", seen, '0);
        check("R4", "still powered down", N'(pd_done), N'(1));

        // R7/R8: wake, first output after stabilization
        pd_req_n = 1'b1;
        k = 0;
        while (clk_out == '0 && k < STAB + 40) begin tick(); k++; end
        check("R7", "no output before stabilization", N'(k >= STAB + 3), N'(1));
        check("R8", "outputs resumed", N'(clk_out != '0), N'(1));
        tick(30);

        // R5: release during gating does not abort
        pd_req_n = 1'b0; tick(3); pd_req_n = 1'b1;
        wait_done("R5", 80);
        k = 0;
        while (!osc_en && k < 20) begin tick(); k++; end
        check("R5", "wake after completed sequence", N'(osc_en), N'(1));
        tick(STAB + 30);

        // R9: re-assert during stabilization
        pd_req_n = 1'b0;
        wait_done("R9", 80);
        pd_req_n = 1'b1; tick(8);
        pd_req_n = 1'b0;
        seen = '0;
        repeat (10) begin tick(); seen |= clk_out; end
        check("R9", "back to power-down", N'(pd_done), N'(1));
        check("R9", "no pulse escaped", seen, '0);
        pd_req_n = 1'b1;
        tick(STAB + 40);
        check("R8", "running after final wake", N'(osc_en && !pd_done), N'(1));
        summary();
    end
endmodule